// File: doc/BRIEF.md
# Address Translation Unit with Fault Capture

This block turns 32-bit virtual addresses into physical ones for byte, halfword and word loads and stores. It uses a small fully associative translation buffer that is searched in a single cycle. A request is presented for one clock with its address, a user-mode flag, a write flag and a width code. One cycle later the block answers in one of two ways. It raises a done strobe with the physical address, or it raises an exception strobe with a 4-bit cause.

The block tests each request in a fixed order: alignment, then privilege, then whether a matching entry exists, whether that entry is valid, and whether it allows writes. When a request faults, the block keeps a snapshot for the trap handler. The snapshot holds the whole faulting address and a 3-bit descriptor of the access (direction and width). When the fault came from the buffer lookup, it also holds the faulting page.

Software reaches five numbered registers through a read/write register port. A buffer-write strobe copies the staged page and frame registers into the entry selected by the index register.

Top module: `tlbx_mmu`

## Requirements
- R1: An access is misaligned, and answers cause 1, in three cases: a word access (width 2) with address bits [1:0] non-zero, a halfword access (width 1) with bit 0 set, or any access with the reserved width code 3. Byte accesses (width 0) are never misaligned. This check comes before every other check.
- R2: A user-mode request (req_user=1) to an address with bit 31 set answers cause 2, provided it passed R1.
- R3: A request sampled with req_valid=1 gives, one cycle later, exactly one of rsp_done or rsp_exc for one cycle. On rsp_done, rsp_paddr is {frame, vaddr[11:0]}. No request means no strobe.
- R4: When no entry's page equals vaddr[31:12], the request answers cause 3 (miss).
- R5: When the matching entry has its valid bit clear, the request answers cause 4.
- R6: A write (req_write=1) through a valid entry whose write-enable bit is clear answers cause 5. A read through the same entry translates.
- R7: When several entries hold the same page, the lowest-numbered entry supplies the translation.
- R8: On causes 3, 4 and 5, register 2 (page register) is loaded with {vaddr[31:12], 12'b0}. On causes 1 and 2 it keeps its value.
- R9: On every fault, register 4 takes the full virtual address, and register 5 takes {write, width[1:0]} in bits [2:0] (bit 2 = 1 for a write).
- R10: The register port numbers are 1 = index, 2 = page, 3 = frame, 4 = bad address, 5 = access descriptor. Reads return the register on sr_rdata. Writes keep these bits: index [4:0], page [31:12], frame [31:12] plus write-enable bit 1 and valid bit 0, bad address all 32 bits, descriptor [2:0]. A read or write strobe with any other number raises sr_illegal and changes nothing.
- R11: A pulse on tlb_wr writes the entry at the index register, taking the page from register 2 and the frame, write-enable bit and valid bit from register 3.
- R12: After reset, all five registers read 0 and every entry holds page 0 with valid clear. So a page-0 access answers cause 4, and any other page answers cause 3.
- R13: When a fault capture and a software write hit the same register in the same cycle, the captured value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | Request issued in user mode |
| req_write | input | 1 | 1 = store, 0 = load |
| req_width | input | 2 | 0 byte, 1 half, 2 word, 3 reserved |
| rsp_done | output | 1 | Translation succeeded |
| rsp_exc | output | 1 | Request faulted |
| rsp_cause | output | 4 | Fault cause (1..5), 0 when no fault |
| rsp_paddr | output | 32 | Physical address, meaningful with rsp_done |
| sr_num | input | 4 | Register number |
| sr_rd | input | 1 | Register read strobe |
| sr_wr | input | 1 | Register write strobe |
| sr_wdata | input | 32 | Register write data |
| sr_rdata | output | 32 | Register read data |
| sr_illegal | output | 1 | Strobe with an unknown register number |
| tlb_wr | input | 1 | Copy staged registers into the indexed entry |

## Verification
The bench goes after the ordering of checks. A misaligned user access to a kernel address must report misalignment and not privilege. A misaligned word aimed at an invalid entry must report misalignment and not an invalid entry. A design that checked in the wrong order would report the later cause. It programs two entries with the same page and expects the lower one's frame. A reversed priority encoder would return the other frame. It tests that non-lookup faults leave the page register alone, and that a software write to the bad-address register in the same cycle as a fault loses. Designs that got these wrong would show a stale page, or would show the software value.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int VA_W      = 32;
    localparam int PAGE_W    = 20;
    localparam int OFF_W     = VA_W - PAGE_W;
    localparam int SR_NUM_W  = 4;
    localparam int DESC_W    = 3;

    localparam logic [SR_NUM_W-1:0] SR_INDEX   = 4'd1;
    localparam logic [SR_NUM_W-1:0] SR_PAGE    = 4'd2;
    localparam logic [SR_NUM_W-1:0] SR_FRAME   = 4'd3;
    localparam logic [SR_NUM_W-1:0] SR_BADADDR = 4'd4;
    localparam logic [SR_NUM_W-1:0] SR_BADACCS = 4'd5;

    typedef enum logic [1:0] {
        WID_BYTE = 2'd0,
        WID_HALF = 2'd1,
        WID_WORD = 2'd2,
        WID_RSVD = 2'd3
    } width_e;

    typedef enum logic [3:0] {
        CAUSE_NONE  = 4'd0,
        CAUSE_ALIGN = 4'd1,
        CAUSE_PRIV  = 4'd2,
        CAUSE_MISS  = 4'd3,
        CAUSE_INVAL = 4'd4,
        CAUSE_WPROT = 4'd5
    } cause_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [PAGE_W-1:0] frame;
        logic              wen;
        logic              vld;
    } tlb_entry_t;

    typedef struct packed {
        logic              hit;
        logic              vld;
        logic              wen;
        logic [PAGE_W-1:0] frame;
    } lookup_t;

    typedef struct packed {
        logic   fault;
        logic   tlb_class;
        cause_e cause;
    } verdict_t;

    function automatic logic is_misaligned(input width_e w, input logic [1:0] low);
        case (w)
            WID_BYTE: return 1'b0;
            WID_HALF: return low[0];
            WID_WORD: return |low;
            default:  return 1'b1;
        endcase
    endfunction

    function automatic logic [DESC_W-1:0] access_desc(input logic wr, input width_e w);
        return {wr, w};
    endfunction

    function automatic logic sr_known(input logic [SR_NUM_W-1:0] n);
        return (n >= SR_INDEX) && (n <= SR_BADACCS);
    endfunction

endpackage

// File: rtl/tlbx_cam.sv
module tlbx_cam
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_entry_t        wr_entry,
    input  logic [PAGE_W-1:0] lk_page,
    output lookup_t           lk
);

    tlb_entry_t         entry_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) entry_q[i] <= '0;
        end else if (wr_en) begin
            entry_q[wr_idx] <= wr_entry;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign match[g] = (entry_q[g].page == lk_page);
    end

    // scan from the top so the lowest matching index is the last to write
    always_comb begin
        lk = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk.hit   = 1'b1;
                lk.vld   = entry_q[i].vld;
                lk.wen   = entry_q[i].wen;
                lk.frame = entry_q[i].frame;
            end
        end
    end

endmodule

// File: rtl/tlbx_check.sv
module tlbx_check
    import tlbx_pkg::*;
(
    input  logic             va_top,
    input  logic [OFF_W-1:0] va_off,
    input  logic             user,
    input  logic             write,
    input  width_e           width,
    input  lookup_t          lk,
    output verdict_t         verdict,
    output logic [VA_W-1:0]  paddr
);

    always_comb begin
        verdict       = '0;
        verdict.cause = CAUSE_NONE;
        if (is_misaligned(width, va_off[1:0])) begin
            verdict.cause = CAUSE_ALIGN;
        end else if (user && va_top) begin
            verdict.cause = CAUSE_PRIV;
        end else if (!lk.hit) begin
            verdict.cause     = CAUSE_MISS;
            verdict.tlb_class = 1'b1;
        end else if (!lk.vld) begin
            verdict.cause     = CAUSE_INVAL;
            verdict.tlb_class = 1'b1;
        end else if (write && !lk.wen) begin
            verdict.cause     = CAUSE_WPROT;
            verdict.tlb_class = 1'b1;
        end
        verdict.fault = (verdict.cause != CAUSE_NONE);
    end

    assign paddr = {lk.frame, va_off};

endmodule

// File: rtl/tlbx_fault_regs.sv
module tlbx_fault_regs
    import tlbx_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap_en,
    input  logic                cap_tlb,
    input  logic [VA_W-1:0]     cap_vaddr,
    input  logic [DESC_W-1:0]   cap_desc,
    input  logic [SR_NUM_W-1:0] sr_num,
    input  logic                sr_rd,
    input  logic                sr_wr,
    input  logic [VA_W-1:0]     sr_wdata,
    output logic [VA_W-1:0]     sr_rdata,
    output logic                sr_illegal,
    output logic [IDX_W-1:0]    index_q,
    output logic [PAGE_W-1:0]   page_q,
    output logic [PAGE_W-1:0]   frame_q,
    output logic                fwen_q,
    output logic                fvld_q,
    output logic [VA_W-1:0]     badaddr_q,
    output logic [DESC_W-1:0]   badaccs_q
);

    logic known;
    assign known      = sr_known(sr_num);
    assign sr_illegal = (sr_rd || sr_wr) && !known;

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q   <= '0;
            page_q    <= '0;
            frame_q   <= '0;
            fwen_q    <= 1'b0;
            fvld_q    <= 1'b0;
            badaddr_q <= '0;
            badaccs_q <= '0;
        end else begin
            if (sr_wr && known) begin
                case (sr_num)
                    SR_INDEX:   index_q <= sr_wdata[IDX_W-1:0];
                    SR_PAGE:    page_q  <= sr_wdata[VA_W-1:OFF_W];
                    SR_FRAME: begin
                        frame_q <= sr_wdata[VA_W-1:OFF_W];
                        fwen_q  <= sr_wdata[1];
                        fvld_q  <= sr_wdata[0];
                    end
                    SR_BADADDR: badaddr_q <= sr_wdata;
                    SR_BADACCS: badaccs_q <= sr_wdata[DESC_W-1:0];
                    default: ;
                endcase
            end
            // capture is placed last so it overrides a same-cycle software write
            if (cap_en) begin
                badaddr_q <= cap_vaddr;
                badaccs_q <= cap_desc;
                if (cap_tlb) page_q <= cap_vaddr[VA_W-1:OFF_W];
            end
        end
    end

    always_comb begin
        sr_rdata = '0;
        case (sr_num)
            SR_INDEX:   sr_rdata = {{(VA_W-IDX_W){1'b0}}, index_q};
            SR_PAGE:    sr_rdata = {page_q, {OFF_W{1'b0}}};
            SR_FRAME:   sr_rdata = {frame_q, {(OFF_W-2){1'b0}}, fwen_q, fvld_q};
            SR_BADADDR: sr_rdata = badaddr_q;
            SR_BADACCS: sr_rdata = {{(VA_W-DESC_W){1'b0}}, badaccs_q};
            default:    sr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tlbx_mmu.sv
module tlbx_mmu
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic        req_user,
    input  logic        req_write,
    input  logic [1:0]  req_width,
    output logic        rsp_done,
    output logic        rsp_exc,
    output logic [3:0]  rsp_cause,
    output logic [31:0] rsp_paddr,
    input  logic [3:0]  sr_num,
    input  logic        sr_rd,
    input  logic        sr_wr,
    input  logic [31:0] sr_wdata,
    output logic [31:0] sr_rdata,
    output logic        sr_illegal,
    input  logic        tlb_wr
);

    localparam int IDX_W = $clog2(ENTRIES);

    lookup_t           lk;
    verdict_t          verdict;
    logic [VA_W-1:0]   xl_paddr;
    tlb_entry_t        staged;
    logic [IDX_W-1:0]  fr_index;
    logic [PAGE_W-1:0] fr_page;
    logic [PAGE_W-1:0] fr_frame;
    logic              fr_wen;
    logic              fr_vld;
    logic [VA_W-1:0]   fr_badaddr;
    logic [DESC_W-1:0] fr_badaccs;
    logic              cap_en;

    assign staged = '{page: fr_page, frame: fr_frame, wen: fr_wen, vld: fr_vld};

    tlbx_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_cam (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tlb_wr),
        .wr_idx   (fr_index),
        .wr_entry (staged),
        .lk_page  (req_vaddr[VA_W-1:OFF_W]),
        .lk       (lk)
    );

    tlbx_check u_check (
        .va_top  (req_vaddr[VA_W-1]),
        .va_off  (req_vaddr[OFF_W-1:0]),
        .user    (req_user),
        .write   (req_write),
        .width   (width_e'(req_width)),
        .lk      (lk),
        .verdict (verdict),
        .paddr   (xl_paddr)
    );

    assign cap_en = req_valid && verdict.fault;

    tlbx_fault_regs #(.IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cap_en     (cap_en),
        .cap_tlb    (verdict.tlb_class),
        .cap_vaddr  (req_vaddr),
        .cap_desc   (access_desc(req_write, width_e'(req_width))),
        .sr_num     (sr_num),
        .sr_rd      (sr_rd),
        .sr_wr      (sr_wr),
        .sr_wdata   (sr_wdata),
        .sr_rdata   (sr_rdata),
        .sr_illegal (sr_illegal),
        .index_q    (fr_index),
        .page_q     (fr_page),
        .frame_q    (fr_frame),
        .fwen_q     (fr_wen),
        .fvld_q     (fr_vld),
        .badaddr_q  (fr_badaddr),
        .badaccs_q  (fr_badaccs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_exc   <= 1'b0;
            rsp_cause <= CAUSE_NONE;
            rsp_paddr <= '0;
        end else begin
            rsp_done  <= req_valid && !verdict.fault;
            rsp_exc   <= cap_en;
            rsp_cause <= req_valid ? verdict.cause : CAUSE_NONE;
            rsp_paddr <= xl_paddr;
        end
    end

endmodule

// File: rtl/tlbx_mmu_chk.sv
module tlbx_mmu_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        req_user,
    input logic        req_write,
    input logic [1:0]  req_width,
    input logic        rsp_done,
    input logic        rsp_exc,
    input logic [3:0]  rsp_cause,
    input logic [31:0] rsp_paddr,
    input logic [3:0]  sr_num,
    input logic        sr_rd,
    input logic        sr_wr,
    input logic        sr_illegal,
    input logic [31:0] fr_badaddr,
    input logic [2:0]  fr_badaccs
);

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !(rsp_done && rsp_exc));

    assert_req_answered_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_done || rsp_exc));

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_done || rsp_exc) |-> $past(req_valid));

    assert_offset_passes_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> rsp_paddr[11:0] == $past(req_vaddr[11:0]));

    assert_word_misalign_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_width == 2'd2 && req_vaddr[1:0] != 2'd0)
        |=> (rsp_exc && rsp_cause == 4'd1));

    assert_priv_source_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_exc && rsp_cause == 4'd2) |-> ($past(req_user) && $past(req_vaddr[31])));

    assert_badaddr_capture_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_exc |-> fr_badaddr == $past(req_vaddr));

    assert_badaccs_capture_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_exc |-> fr_badaccs == {$past(req_write), $past(req_width)});

    assert_illegal_number_R10: assert property (@(posedge clk) disable iff (rst)
        sr_illegal |-> ((sr_rd || sr_wr) && (sr_num == 4'd0 || sr_num > 4'd5)));

endmodule

bind tlbx_mmu tlbx_mmu_chk u_chk (.*);

// File: tb/tlbx_mmu_tb.sv
module tlbx_mmu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    typedef struct packed {
        logic        user;
        logic        wr;
        logic [1:0]  wid;
        logic [31:0] va;
        logic        exc;
        logic [3:0]  cause;
        logic [31:0] pa;
    } vec_t;

    // user, write, width, vaddr, exc, cause, paddr
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 2'd2, 32'h0040_0010, 1'b0, 4'd0, 32'h1234_5010},
        '{1'b1, 1'b1, 2'd0, 32'h0040_0FFF, 1'b0, 4'd0, 32'h1234_5FFF},
        '{1'b1, 1'b0, 2'd1, 32'h0040_1002, 1'b0, 4'd0, 32'h0ABC_D002},
        '{1'b0, 1'b1, 2'd2, 32'h0040_1004, 1'b1, 4'd5, 32'h0},
        '{1'b0, 1'b0, 2'd0, 32'h0040_2000, 1'b1, 4'd4, 32'h0},
        '{1'b0, 1'b0, 2'd2, 32'h0099_9000, 1'b1, 4'd3, 32'h0},
        '{1'b1, 1'b0, 2'd2, 32'h8000_1000, 1'b1, 4'd2, 32'h0},
        '{1'b0, 1'b0, 2'd2, 32'h8000_1008, 1'b0, 4'd0, 32'h2222_2008},
        '{1'b1, 1'b0, 2'd2, 32'h8000_1002, 1'b1, 4'd1, 32'h0},
        '{1'b0, 1'b0, 2'd1, 32'h0040_0011, 1'b1, 4'd1, 32'h0},
        '{1'b0, 1'b0, 2'd1, 32'h0040_0012, 1'b0, 4'd0, 32'h1234_5012},
        '{1'b0, 1'b1, 2'd2, 32'h0040_3100, 1'b0, 4'd0, 32'h3333_3100},
        '{1'b0, 1'b0, 2'd3, 32'h0040_0000, 1'b1, 4'd1, 32'h0},
        '{1'b1, 1'b0, 2'd2, 32'h0099_9000, 1'b1, 4'd3, 32'h0},
        '{1'b0, 1'b1, 2'd2, 32'h0040_2001, 1'b1, 4'd1, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_user = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_width = '0;
    logic        rsp_done;
    logic        rsp_exc;
    logic [3:0]  rsp_cause;
    logic [31:0] rsp_paddr;
    logic [3:0]  sr_num = '0;
    logic        sr_rd = 1'b0;
    logic        sr_wr = 1'b0;
    logic [31:0] sr_wdata = '0;
    logic [31:0] sr_rdata;
    logic        sr_illegal;
    logic        tlb_wr = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_page = '0;

    tlbx_mmu u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_user(req_user),
        .req_write(req_write), .req_width(req_width),
        .rsp_done(rsp_done), .rsp_exc(rsp_exc), .rsp_cause(rsp_cause),
        .rsp_paddr(rsp_paddr),
        .sr_num(sr_num), .sr_rd(sr_rd), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .sr_rdata(sr_rdata), .sr_illegal(sr_illegal), .tlb_wr(tlb_wr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic sr_write(input logic [3:0] num, input logic [31:0] data);
        @(negedge clk);
        sr_num = num; sr_wdata = data; sr_wr = 1'b1;
        @(negedge clk);
        sr_wr = 1'b0;
    endtask

    task automatic sr_check(input string tag, input logic [3:0] num, input logic [31:0] exp);
        @(negedge clk);
        sr_num = num; sr_rd = 1'b1;
        #1;
        check(tag, sr_rdata, exp);
        check({tag, " no illegal flag"}, {31'b0, sr_illegal}, 32'd0);
        sr_rd = 1'b0;
    endtask

    task automatic program_entry(input int idx, input logic [19:0] page,
                                 input logic [19:0] frame, input logic we, input logic v);
        sr_write(4'd1, idx);
        sr_write(4'd2, {page, 12'h0});
        sr_write(4'd3, {frame, 10'h0, we, v});
        exp_page = {page, 12'h0};
        @(negedge clk);
        tlb_wr = 1'b1;
        @(negedge clk);
        tlb_wr = 1'b0;
    endtask

    // drives one request; result is sampled at the negedge after the capturing edge
    task automatic do_req(input logic u, input logic w, input logic [1:0] wid,
                          input logic [31:0] va);
        @(negedge clk);
        req_valid = 1'b1; req_user = u; req_write = w; req_width = wid; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd1: return "R1 misaligned";
            4'd2: return "R2 privileged";
            4'd3: return "R4 miss";
            4'd4: return "R5 invalid";
            4'd5: return "R6 write protect";
            default: return "R3 translate";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        check("R12 done low after reset", {31'b0, rsp_done}, 32'd0);
        check("R12 exc low after reset", {31'b0, rsp_exc}, 32'd0);
        for (int r = 1; r <= 5; r++) sr_check("R12 register zero after reset", 4'(r), 32'd0);
        do_req(1'b0, 1'b0, 2'd2, 32'h0000_0040);
        check("R12 page 0 hits cleared entry", {27'b0, rsp_exc, rsp_cause}, {27'b0, 1'b1, 4'd4});
        do_req(1'b0, 1'b0, 2'd2, 32'h0000_5040);
        check("R12 other page misses", {27'b0, rsp_exc, rsp_cause}, {27'b0, 1'b1, 4'd3});
        exp_page = 32'h0000_5000;

        // R3 no request gives no strobe
        @(negedge clk);
        check("R3 idle no strobe", {30'b0, rsp_done, rsp_exc}, 32'd0);

        // R11 program entries
        program_entry(0, 20'h00400, 20'h12345, 1'b1, 1'b1);
        program_entry(1, 20'h00401, 20'h0ABCD, 1'b0, 1'b1);
        program_entry(2, 20'h00402, 20'h11111, 1'b1, 1'b0);
        program_entry(3, 20'h80001, 20'h22222, 1'b1, 1'b1);
        program_entry(7, 20'h00403, 20'h44444, 1'b1, 1'b1);
        program_entry(5, 20'h00403, 20'h33333, 1'b1, 1'b1); // R7 duplicate, lower index
        sr_check("R11 index register readback", 4'd1, 32'd5);
        sr_check("R11 frame register readback", 4'd3, 32'h3333_3003);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            do_req(VECS[i].user, VECS[i].wr, VECS[i].wid, VECS[i].va);
            check({tag_of(VECS[i].cause), " exc strobe"}, {31'b0, rsp_exc}, {31'b0, VECS[i].exc});
            check({tag_of(VECS[i].cause), " done strobe"}, {31'b0, rsp_done}, {31'b0, !VECS[i].exc});
            if (VECS[i].exc) begin
                check({tag_of(VECS[i].cause), " cause"}, {28'b0, rsp_cause}, {28'b0, VECS[i].cause});
                if (VECS[i].cause >= 4'd3) exp_page = {VECS[i].va[31:12], 12'h0};
                sr_check("R9 bad address captured", 4'd4, VECS[i].va);
                sr_check("R9 access descriptor captured", 4'd5, {29'b0, VECS[i].wr, VECS[i].wid});
                sr_check("R8 page register", 4'd2, exp_page);
            end else begin
                check("R3 R7 physical address", rsp_paddr, VECS[i].pa);
            end
        end

        // R13 capture beats same-cycle software write
        @(negedge clk);
        req_valid = 1'b1; req_user = 1'b0; req_write = 1'b1; req_width = 2'd0;
        req_vaddr = 32'h0077_7123;
        sr_num = 4'd4; sr_wdata = 32'hDEAD_0000; sr_wr = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; sr_wr = 1'b0;
        check("R13 fault strobe", {27'b0, rsp_exc, rsp_cause}, {27'b0, 1'b1, 4'd3});
        sr_check("R13 bad address keeps captured value", 4'd4, 32'h0077_7123);
        sr_check("R13 descriptor", 4'd5, 32'd4);

        // R10 write masks
        sr_write(4'd5, 32'hFFFF_FFFF);
        sr_check("R10 descriptor keeps 3 bits", 4'd5, 32'd7);
        sr_write(4'd1, 32'hFFFF_FFFF);
        sr_check("R10 index keeps 5 bits", 4'd1, 32'h0000_001F);
        sr_write(4'd2, 32'hFFFF_FFFF);
        sr_check("R10 page keeps upper 20 bits", 4'd2, 32'hFFFF_F000);
        sr_write(4'd3, 32'hFFFF_FFFF);
        sr_check("R10 frame keeps upper 20 and flags", 4'd3, 32'hFFFF_F003);
        sr_write(4'd4, 32'h1357_9BDF);
        sr_check("R10 bad address full width", 4'd4, 32'h1357_9BDF);

        // R10 unknown numbers
        for (int n = 0; n < 16; n++) begin
            if (n == 0 || n > 5) begin
                @(negedge clk);
                sr_num = 4'(n); sr_wr = 1'b1; sr_wdata = 32'h0;
                #1;
                check("R10 illegal flag on unknown write", {31'b0, sr_illegal}, 32'd1);
                sr_wr = 1'b0; sr_rd = 1'b1;
                #1;
                check("R10 illegal flag on unknown read", {31'b0, sr_illegal}, 32'd1);
                sr_rd = 1'b0;
            end
        end
        sr_check("R10 unknown writes changed nothing", 4'd4, 32'h1357_9BDF);
        sr_check("R10 unknown writes left descriptor", 4'd5, 32'd7);

        // R6 read through read-only entry still translates
        do_req(1'b0, 1'b0, 2'd2, 32'h0040_1ABC);
        check("R6 read through read-only entry", rsp_paddr, 32'h0ABC_DABC);
        check("R6 read gives done", {31'b0, rsp_done}, 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule